// File: doc/BRIEF.md
# Command Queue Register Block for an Interrupt Translation Unit

This block holds the software-visible registers that set up and drive the command queue of an interrupt translation unit. Software programs a 64-bit queue base register with the physical location, size and valid flag of an in-memory ring of commands. It then moves a write pointer forward to post work and turns the unit on through a control register. The block tracks a read pointer. While that pointer trails the write pointer, and the unit is enabled with a valid base, it fetches one 32-byte command at a time over a memory-read request port and hands each command to a downstream consumer.

A small state machine runs the fetch loop. `FS_IDLE` moves to `FS_ISSUE` when fetching is allowed and the pointers differ. `FS_ISSUE` holds the request until it is accepted and moves to `FS_WAIT`; it falls back to `FS_IDLE` if the enable or the valid flag drops first. `FS_WAIT` moves to `FS_DELIVER` when the response arrives. `FS_DELIVER` presents the command for one cycle, advances the read pointer and returns to `FS_IDLE`. An accepted base write forces the machine back to `FS_IDLE` from any state.

The register bus is flat and single-cycle. A write takes effect at the clock edge on which `bus_valid` and `bus_write` are high. Read data is combinational from `bus_sel`, `bus_hi` and `bus_wide`.

Top module: `itq_cmdq_regs`

## Requirements
- R1: The control register (select 0) bit 0 is the enable bit; software writes it and reads it back. Writes reach it only through a 64-bit access or a 32-bit access with `bus_hi`=0.
- R2: Control bit 31 reads 1 exactly when the read and write pointers are equal, and all other control bits read 0. Software cannot write bit 31.
- R3: The type register (select 1) always reads 0xFF01EF01, and writes to it have no effect. In that value, bit 0 flags physical LPI support, bits [12:8] and [17:13] each hold 0x0F, bits [31:24] hold 0xFF, and bit 19 is 0.
- R4: While the enable bit is 1, writes to the queue base register (select 2) are ignored.
- R5: An accepted queue base write sets the read pointer to 0 and the write pointer to 0.
- R6: Each 64-bit register accepts a 64-bit access (`bus_wide`=1, full `bus_wdata`/`bus_rdata`) or a 32-bit access (`bus_wide`=0) to the low half (`bus_hi`=0) or the high half (`bus_hi`=1). A 32-bit access uses bits [31:0] of the data buses, returns 0 in the upper read bits, and updates only the addressed half.
- R7: The queue holds (base[7:0]+1) x 4096 bytes. The address of a fetch is base[47:12] shifted left by 12, plus the read pointer.
- R8: A write pointer value (select 3) is aligned down to a multiple of 32. A value at or beyond the queue size is ignored and leaves the register unchanged.
- R9: Commands are fetched only while the enable bit and base bit 63 are both 1, and only while the read pointer differs from the write pointer. The read pointer advances by 32 per delivered command and wraps to 0 at the queue size.
- R10: The read pointer register (select 4) is read-only. Reset clears the enable bit, the base register and both pointers to 0. Selects 5 to 7 read 0.
- R11: `cmd_valid` is high for exactly one cycle per command, the cycle after `mem_rsp_valid`, with `cmd_data` equal to the response data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 3 | Register select: 0 control, 1 type, 2 base, 3 write pointer, 4 read pointer |
| bus_hi | input | 1 | For 32-bit accesses: 1 selects the upper half (byte offset 4) |
| bus_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data (combinational) |
| mem_req_valid | output | 1 | Command fetch request |
| mem_req_ready | input | 1 | Fetch request accepted |
| mem_req_addr | output | PA_W | Physical address of the command |
| mem_rsp_valid | input | 1 | Fetch response valid |
| mem_rsp_data | input | CMD_BYTES*8 | Fetched command |
| cmd_valid | output | 1 | Command handed to the consumer |
| cmd_data | output | CMD_BYTES*8 | Command contents |

## Verification
A read pointer that moves wrongly shows at the ports in two ways. The next fetch goes to the wrong `mem_req_addr`, and the quiescent bit in the control register reads wrongly on the very next read. A missed wrap sends a fetch outside the queue within four cycles of the last slot. Base-lock and pointer-reset faults appear on the first read-back after the write. Pointer alignment and bound faults appear either on that read-back or as a wrong number of delivered commands. The directed scenarios therefore count delivered commands, compare their addresses, and read every register back after each write.

// File: rtl/itq_pkg.sv
package itq_pkg;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_ISSUE,
        FS_WAIT,
        FS_DELIVER
    } fetch_state_e;

    localparam logic [2:0] SEL_CTRL  = 3'd0;
    localparam logic [2:0] SEL_KIND  = 3'd1;
    localparam logic [2:0] SEL_QBASE = 3'd2;
    localparam logic [2:0] SEL_WPTR  = 3'd3;
    localparam logic [2:0] SEL_RPTR  = 3'd4;

    // Capability word: LPI flag, ID bits, device bits, collection count.
    localparam logic [63:0] KIND_VALUE = 64'h1
                                       | (64'h0F << 8)
                                       | (64'h0F << 13)
                                       | (64'hFF << 24);

    // Merge a write into a 64-bit register, touching only the addressed half.
    function automatic logic [63:0] merge_half(input logic [63:0] old_v,
                                               input logic [63:0] new_v,
                                               input logic        hi,
                                               input logic        wide);
        logic [63:0] res;
        if (wide)
            res = new_v;
        else if (hi)
            res = {new_v[31:0], old_v[31:0]};
        else
            res = {old_v[63:32], new_v[31:0]};
        return res;
    endfunction

endpackage

// File: rtl/itq_regfile.sv
module itq_regfile
    import itq_pkg::*;
#(
    parameter int PAGE_SHIFT = 12,
    parameter int CMD_BYTES  = 32,
    localparam int PTR_W     = 8 + PAGE_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [2:0]       bus_sel,
    input  logic             bus_hi,
    input  logic             bus_wide,
    input  logic [63:0]      bus_wdata,
    input  logic [PTR_W-1:0] rd_ptr,
    output logic [63:0]      bus_rdata,
    output logic             enable,
    output logic [63:0]      qbase,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W:0]   qsize,
    output logic             base_clr
);

    logic        wr_en;
    logic        ctrl_hit;
    logic        wp_hit;
    logic        wp_fits;
    logic [63:0] wp_cand;
    logic [63:0] wp_align;
    logic [63:0] full_rd;

    assign wr_en    = bus_valid && bus_write;
    assign ctrl_hit = wr_en && (bus_sel == SEL_CTRL) && (bus_wide || !bus_hi);
    assign base_clr = wr_en && (bus_sel == SEL_QBASE) && !enable;
    assign wp_hit   = wr_en && (bus_sel == SEL_WPTR);

    assign qsize    = (PTR_W+1)'({1'b0, qbase[7:0]} + 9'd1) << PAGE_SHIFT;

    assign wp_cand  = merge_half(64'(wr_ptr), bus_wdata, bus_hi, bus_wide);
    assign wp_align = wp_cand & ~64'(CMD_BYTES - 1);
    assign wp_fits  = wp_align < 64'(qsize);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= 1'b0;
            qbase  <= '0;
            wr_ptr <= '0;
        end else begin
            if (ctrl_hit)
                enable <= bus_wdata[0];
            if (base_clr) begin
                qbase  <= merge_half(qbase, bus_wdata, bus_hi, bus_wide);
                wr_ptr <= '0;
            end else if (wp_hit && wp_fits) begin
                wr_ptr <= wp_align[PTR_W-1:0];
            end
        end
    end

    always_comb begin
        unique case (bus_sel)
            SEL_CTRL:  full_rd = {32'h0, (rd_ptr == wr_ptr), 30'h0, enable};
            SEL_KIND:  full_rd = KIND_VALUE;
            SEL_QBASE: full_rd = qbase;
            SEL_WPTR:  full_rd = 64'(wr_ptr);
            SEL_RPTR:  full_rd = 64'(rd_ptr);
            default:   full_rd = '0;
        endcase
    end

    always_comb begin
        if (bus_wide)
            bus_rdata = full_rd;
        else if (bus_hi)
            bus_rdata = {32'h0, full_rd[63:32]};
        else
            bus_rdata = {32'h0, full_rd[31:0]};
    end

endmodule

// File: rtl/itq_fetch.sv
module itq_fetch
    import itq_pkg::*;
#(
    parameter int PA_W       = 48,
    parameter int PAGE_SHIFT = 12,
    parameter int CMD_BYTES  = 32,
    localparam int PTR_W     = 8 + PAGE_SHIFT,
    localparam int CMD_W     = CMD_BYTES * 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic                     base_valid,
    input  logic [PA_W-1:PAGE_SHIFT] base_addr,
    input  logic [PTR_W:0]           qsize,
    input  logic [PTR_W-1:0]         wr_ptr,
    input  logic                     clr,
    input  logic                     mem_req_ready,
    input  logic                     mem_rsp_valid,
    input  logic [CMD_W-1:0]         mem_rsp_data,
    output logic [PTR_W-1:0]         rd_ptr,
    output logic                     mem_req_valid,
    output logic [PA_W-1:0]          mem_req_addr,
    output logic                     cmd_valid,
    output logic [CMD_W-1:0]         cmd_data
);

    fetch_state_e state, nxt;
    logic         go;
    logic         pending;
    logic [PTR_W:0] rd_step;

    assign go           = enable && base_valid;
    assign pending      = rd_ptr != wr_ptr;
    assign rd_step      = {1'b0, rd_ptr} + (PTR_W+1)'(CMD_BYTES);
    assign mem_req_addr = {base_addr, {PAGE_SHIFT{1'b0}}} + PA_W'(rd_ptr);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            state <= FS_IDLE;
        else
            state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            FS_IDLE:    if (go && pending) nxt = FS_ISSUE;
            FS_ISSUE:   if (!go) nxt = FS_IDLE;
                        else if (mem_req_ready) nxt = FS_WAIT;
            FS_WAIT:    if (mem_rsp_valid) nxt = FS_DELIVER;
            FS_DELIVER: nxt = FS_IDLE;
            default:    nxt = FS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req_valid = 1'b0;
        cmd_valid     = 1'b0;
        unique case (state)
            FS_ISSUE:   mem_req_valid = go;
            FS_DELIVER: cmd_valid     = 1'b1;
            default:    ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr   <= '0;
            cmd_data <= '0;
        end else begin
            if (state == FS_WAIT && mem_rsp_valid)
                cmd_data <= mem_rsp_data;
            if (clr)
                rd_ptr <= '0;
            else if (state == FS_DELIVER)
                rd_ptr <= (rd_step >= qsize) ? '0 : rd_step[PTR_W-1:0];
        end
    end

endmodule

// File: rtl/itq_cmdq_regs.sv
module itq_cmdq_regs
    import itq_pkg::*;
#(
    parameter int PA_W       = 48,
    parameter int PAGE_SHIFT = 12,
    parameter int CMD_BYTES  = 32,
    localparam int PTR_W     = 8 + PAGE_SHIFT,
    localparam int CMD_W     = CMD_BYTES * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [2:0]       bus_sel,
    input  logic             bus_hi,
    input  logic             bus_wide,
    input  logic [63:0]      bus_wdata,
    output logic [63:0]      bus_rdata,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [CMD_W-1:0] mem_rsp_data,
    output logic             cmd_valid,
    output logic [CMD_W-1:0] cmd_data
);

    logic             ctl_enable;
    logic [63:0]      qbase;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W:0]   qsize;
    logic             base_clr;

    itq_regfile #(
        .PAGE_SHIFT (PAGE_SHIFT),
        .CMD_BYTES  (CMD_BYTES)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_sel   (bus_sel),
        .bus_hi    (bus_hi),
        .bus_wide  (bus_wide),
        .bus_wdata (bus_wdata),
        .rd_ptr    (rd_ptr),
        .bus_rdata (bus_rdata),
        .enable    (ctl_enable),
        .qbase     (qbase),
        .wr_ptr    (wr_ptr),
        .qsize     (qsize),
        .base_clr  (base_clr)
    );

    itq_fetch #(
        .PA_W       (PA_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .CMD_BYTES  (CMD_BYTES)
    ) u_fetch (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (ctl_enable),
        .base_valid    (qbase[63]),
        .base_addr     (qbase[PA_W-1:PAGE_SHIFT]),
        .qsize         (qsize),
        .wr_ptr        (wr_ptr),
        .clr           (base_clr),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .rd_ptr        (rd_ptr),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .cmd_valid     (cmd_valid),
        .cmd_data      (cmd_data)
    );

endmodule

// File: rtl/itq_cmdq_checker.sv
module itq_cmdq_checker #(
    parameter int PTR_W     = 20,
    parameter int CMD_BYTES = 32,
    localparam int CMD_SHIFT = $clog2(CMD_BYTES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_valid,
    input logic             bus_write,
    input logic [2:0]       bus_sel,
    input logic             enable,
    input logic [63:0]      qbase,
    input logic [PTR_W-1:0] rd_ptr,
    input logic [PTR_W-1:0] wr_ptr,
    input logic [PTR_W:0]   qsize,
    input logic             cmd_valid
);

    logic base_wr;
    assign base_wr = bus_valid && bus_write && (bus_sel == 3'd2);

    p_base_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr && enable |=> $stable(qbase));

    p_base_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr && !enable |=> (rd_ptr == '0) && (wr_ptr == '0));

    p_wr_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr[CMD_SHIFT-1:0] == '0) && ({1'b0, wr_ptr} < qsize));

    p_rd_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ptr[CMD_SHIFT-1:0] == '0) && ({1'b0, rd_ptr} < qsize));

    p_rd_moves_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !(base_wr && !enable) |=> rd_ptr != $past(rd_ptr));

    p_rd_readonly_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_write && (bus_sel == 3'd4) && !cmd_valid && !(base_wr && !enable)
        |=> $stable(rd_ptr));

    p_cmd_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

endmodule

bind itq_cmdq_regs itq_cmdq_checker #(
    .PTR_W     (PTR_W),
    .CMD_BYTES (CMD_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_sel   (bus_sel),
    .enable    (ctl_enable),
    .qbase     (qbase),
    .rd_ptr    (rd_ptr),
    .wr_ptr    (wr_ptr),
    .qsize     (qsize),
    .cmd_valid (cmd_valid)
);

// File: tb/itq_cmdq_regs_bench.sv
`timescale 1ns/1ps
module itq_cmdq_regs_bench;

    localparam int PA_W  = 48;
    localparam int CMD_W = 256;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_valid, bus_write, bus_hi, bus_wide;
    logic [2:0]       bus_sel;
    logic [63:0]      bus_wdata, bus_rdata;
    logic             mem_req_valid, mem_req_ready, mem_rsp_valid, cmd_valid;
    logic [PA_W-1:0]  mem_req_addr;
    logic [CMD_W-1:0] mem_rsp_data, cmd_data;

    always #4 clk = ~clk;

    itq_cmdq_regs u_itq_cmdq_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_sel(bus_sel),
        .bus_hi(bus_hi), .bus_wide(bus_wide), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int ncmd = 0;
    logic [31:0] cmd_log [0:255];
    logic        pend = 1'b0;
    logic [PA_W-1:0] pend_addr = '0;

    // Memory model: answers one cycle after the request; logs delivered commands.
    initial begin
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            if (cmd_valid) begin
                cmd_log[ncmd % 256] = cmd_data[31:0];
                ncmd++;
            end
            mem_rsp_valid = pend;
            mem_rsp_data  = {8{pend_addr[31:0]}};
            pend      = mem_req_valid;
            pend_addr = mem_req_addr;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] s, input logic hi, input logic wide, input logic [63:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_sel = s; bus_hi = hi; bus_wide = wide; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] s, input logic hi, input logic wide, output logic [63:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_sel = s; bus_hi = hi; bus_wide = wide;
        #1 d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic expect_reg(input string req, input logic [2:0] s, input logic [63:0] exp);
        logic [63:0] v;
        bus_rd(s, 1'b0, 1'b1, v);
        check(req, v, exp);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        expect_reg("R2 R10 control after reset", 3'd0, 64'h8000_0000);
        expect_reg("R3 type value", 3'd1, 64'hFF01_EF01);
        expect_reg("R10 base after reset", 3'd2, 64'h0);
        expect_reg("R10 write pointer after reset", 3'd3, 64'h0);
        expect_reg("R10 read pointer after reset", 3'd4, 64'h0);
        expect_reg("R10 unused select", 3'd6, 64'h0);
    endtask

    task automatic t_kind_ro;
        bus_wr(3'd1, 1'b0, 1'b1, '1);
        expect_reg("R3 type ignores writes", 3'd1, 64'hFF01_EF01);
    endtask

    task automatic t_halves;
        logic [63:0] v;
        bus_wr(3'd2, 1'b0, 1'b1, 64'h8000_0000_0010_0001);
        expect_reg("R6 base 64-bit write", 3'd2, 64'h8000_0000_0010_0001);
        bus_wr(3'd2, 1'b1, 1'b0, 64'h0000_0000_0000_1234);
        expect_reg("R6 base high-half write", 3'd2, 64'h0000_1234_0010_0001);
        bus_rd(3'd2, 1'b1, 1'b0, v);
        check("R6 high-half read", v, 64'h1234);
        bus_wr(3'd2, 1'b0, 1'b0, 64'hFFFF_FFFF_0020_0003);
        expect_reg("R6 base low-half write", 3'd2, 64'h0000_1234_0020_0003);
        bus_rd(3'd2, 1'b0, 1'b0, v);
        check("R6 low-half read", v, 64'h0020_0003);
        bus_wr(3'd2, 1'b0, 1'b1, 64'h8000_0000_0010_0001);
    endtask

    task automatic t_wptr;
        bus_wr(3'd3, 1'b0, 1'b0, 64'h47);
        expect_reg("R8 align down", 3'd3, 64'h40);
        bus_wr(3'd3, 1'b0, 1'b0, 64'h2000);
        expect_reg("R8 value at size ignored", 3'd3, 64'h40);
        bus_wr(3'd3, 1'b0, 1'b0, 64'h1FFF);
        expect_reg("R8 last slot", 3'd3, 64'h1FE0);
        bus_wr(3'd3, 1'b1, 1'b0, 64'h1);
        expect_reg("R8 high-half beyond size ignored", 3'd3, 64'h1FE0);
        bus_wr(3'd2, 1'b0, 1'b1, 64'h8000_0000_0010_0001);
        expect_reg("R5 base write empties write pointer", 3'd3, 64'h0);
        expect_reg("R5 base write empties read pointer", 3'd4, 64'h0);
    endtask

    task automatic t_fetch;
        int n0;
        n0 = ncmd;
        bus_wr(3'd3, 1'b0, 1'b0, 64'h40);
        expect_reg("R2 not quiescent while disabled", 3'd0, 64'h0);
        cycles(12);
        check("R9 no fetch while disabled", 64'(ncmd - n0), 64'h0);
        bus_wr(3'd0, 1'b0, 1'b0, 64'hFFFF_FFFF);
        cycles(16);
        check("R9 two commands delivered", 64'(ncmd - n0), 64'h2);
        check("R7 R11 first command address", 64'(cmd_log[n0 % 256]), 64'h0010_0000);
        check("R7 R11 second command address", 64'(cmd_log[(n0 + 1) % 256]), 64'h0010_0020);
        expect_reg("R9 read pointer after two", 3'd4, 64'h40);
        expect_reg("R1 R2 enabled and quiescent", 3'd0, 64'h8000_0001);
    endtask

    task automatic t_locked;
        bus_wr(3'd2, 1'b0, 1'b1, 64'h8000_0000_0030_0005);
        expect_reg("R4 base locked while enabled", 3'd2, 64'h8000_0000_0010_0001);
        expect_reg("R4 pointers kept while enabled", 3'd4, 64'h40);
        bus_wr(3'd4, 1'b0, 1'b1, 64'h100);
        expect_reg("R10 read pointer read-only", 3'd4, 64'h40);
    endtask

    task automatic t_wrap;
        int n0;
        bus_wr(3'd0, 1'b0, 1'b0, 64'h0);
        expect_reg("R1 enable cleared", 3'd0, 64'h8000_0000);
        bus_wr(3'd2, 1'b0, 1'b1, 64'h8000_0000_0020_0000);
        bus_wr(3'd3, 1'b0, 1'b0, 64'hFE0);
        n0 = ncmd;
        bus_wr(3'd0, 1'b0, 1'b1, 64'h1);
        cycles(127 * 4 + 12);
        check("R9 full page of commands", 64'(ncmd - n0), 64'd127);
        expect_reg("R9 read pointer at last slot", 3'd4, 64'hFE0);
        bus_wr(3'd3, 1'b0, 1'b0, 64'h20);
        cycles(16);
        check("R9 two more commands", 64'(ncmd - n0), 64'd129);
        check("R7 last-slot address", 64'(cmd_log[(n0 + 127) % 256]), 64'h0020_0FE0);
        check("R9 wrapped address", 64'(cmd_log[(n0 + 128) % 256]), 64'h0020_0000);
        expect_reg("R9 read pointer after wrap", 3'd4, 64'h20);
    endtask

    task automatic t_invalid;
        int n0;
        bus_wr(3'd0, 1'b0, 1'b0, 64'h0);
        bus_wr(3'd2, 1'b0, 1'b1, 64'h0000_0000_0010_0000);
        bus_wr(3'd3, 1'b0, 1'b0, 64'h40);
        n0 = ncmd;
        bus_wr(3'd0, 1'b0, 1'b0, 64'h1);
        cycles(20);
        check("R9 no fetch without valid base", 64'(ncmd - n0), 64'h0);
        expect_reg("R9 read pointer held", 3'd4, 64'h0);
        expect_reg("R1 R2 enabled, not quiescent", 3'd0, 64'h1);
        bus_wr(3'd0, 1'b1, 1'b0, 64'h0);
        expect_reg("R1 high-half control write ignored", 3'd0, 64'h1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bus_valid = 1'b0; bus_write = 1'b0; bus_sel = 3'd0;
        bus_hi = 1'b0; bus_wide = 1'b0; bus_wdata = '0;
        mem_req_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_kind_ro();
        t_halves();
        t_wptr();
        t_fetch();
        t_locked();
        t_wrap();
        t_invalid();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule